// File: doc/BRIEF.md
# Dual-Clock Scan Path Register

This block holds the state of a small sequential circuit in a chain of two-port flip-flops. Each flip-flop has two data inputs. One takes the functional next-state value and is loaded by the system clock strobe. The other takes the output of the previous flip-flop in the chain and is loaded by the test clock strobe. Serial data enters the first flip-flop and leaves the last one. This lets a tester set any state, apply one functional clock, and read back the state that was captured.

In RTL, the two clocks are modelled as two enables on one clock: `sck_en` (functional capture) and `tck_en` (serial shift). No scan-enable multiplexer sits in front of the flip-flops. Which enable is asserted decides which data port loads. The two enables must never be asserted in the same cycle. If they are, the state is held and a sticky error flag is set.

The next-state and output logic are a small parameterised placeholder, defined exactly below so that it can be tested. A controller state machine tracks the last operation. Its states are REST (no enable), CAPTURE (functional load), SHIFT (serial shift) and CLASH (both enables seen). From REST, CAPTURE or SHIFT it moves to CLASH when both enables are high. Otherwise it moves to CAPTURE when only `sck_en` is high, to SHIFT when only `tck_en` is high, and to REST when neither is high. CLASH is left only by reset.

Top module: `scanpath_reg`

## Requirements
- R1: While `rst_n` is low, and in the cycles after it rises until an enable is used, all K state bits are 0, `sdo` is 0 and `clash_err` is 0.
- R2: A cycle with `tck_en`=1 and `sck_en`=0 shifts the chain by one place. State bit 0 takes `sdi`, and bit i takes the old bit i-1. `sdo` always shows state bit K-1. `x_in` has no effect on such a cycle.
- R3: A cycle with `sck_en`=1 and `tck_en`=0 loads every state bit with its next-state value at once.
- R4: The next-state value of bit i is s[(i+K-1) mod K] XOR x[i mod N]. That is, the state is rotated one place toward higher indices and XORed with the inputs.
- R5: `z_out` bit j is combinational: s[j mod K] XOR s[(j+1) mod K] XOR x[j mod N].
- R6: A cycle with both enables low leaves the state unchanged, whatever `sdi` and `x_in` are.
- R7: A cycle with both enables high leaves the state unchanged. `clash_err` is 1 from the next cycle onward and stays 1 until reset.
- R8: K shift cycles load a complete vector. The first bit shifted in ends in bit K-1. During the same K shifts, `sdo` presents the old state from bit K-1 down to bit 0, so unloading one vector overlaps with loading the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both operations |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_en | input | 1 | Functional capture strobe (system clock pulse) |
| tck_en | input | 1 | Serial shift strobe (test clock pulse) |
| sdi | input | 1 | Serial scan data input |
| x_in | input | N | Primary inputs to the combinational logic |
| z_out | output | M | Primary outputs of the combinational logic |
| sdo | output | 1 | Serial scan data output (last state bit) |
| clash_err | output | 1 | Sticky flag: both strobes were seen in one cycle |

## Verification
The assertions on shifting, capture and holding assume that at most one of `sck_en` and `tck_en` is high in a cycle. A cycle with both high is covered only by the clash properties. The random stimulus keeps to this assumption: every load, settle, capture and unload sequence pulses only one strobe per cycle. The only cycle that raises both strobes is a single directed cycle near the end of the run, followed by a reset. Between strobes, `sdi` and `x_in` are driven with random values so that the hold and shift-only behaviour can be seen through the unloaded data.

// File: rtl/scanreg_pkg.sv
package scanreg_pkg;

    typedef enum logic [1:0] {
        OP_REST    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_CLASH   = 2'd3
    } scan_op_e;

endpackage

// File: rtl/scanreg_logic.sv
module scanreg_logic #(
    parameter int K = 6,
    parameter int N = 3,
    parameter int M = 2
) (
    input  logic [K-1:0] cur_state,
    input  logic [N-1:0] pin_in,
    output logic [K-1:0] next_state,
    output logic [M-1:0] pin_out
);

    // Next state: rotate toward higher index, then XOR with inputs (R4).
    for (genvar i = 0; i < K; i++) begin : g_next
        localparam int SRC = (i + K - 1) % K;
        localparam int XI  = i % N;
        assign next_state[i] = cur_state[SRC] ^ pin_in[XI];
    end

    // Outputs: parity of two neighbouring state bits and one input (R5).
    for (genvar j = 0; j < M; j++) begin : g_out
        localparam int SA = j % K;
        localparam int SB = (j + 1) % K;
        localparam int XJ = j % N;
        assign pin_out[j] = cur_state[SA] ^ cur_state[SB] ^ pin_in[XJ];
    end

endmodule

// File: rtl/scanreg_cell.sv
module scanreg_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic func_d,
    input  logic func_load,
    input  logic chain_d,
    input  logic chain_load,
    output logic q
);

    // Two-port flip-flop: each data port is paired with its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (func_load)
            q <= func_d;
        else if (chain_load)
            q <= chain_d;
    end

endmodule

// File: rtl/scanreg_chain.sv
module scanreg_chain #(
    parameter int K = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] load_val,
    input  logic         cap_go,
    input  logic         shf_go,
    input  logic         ser_in,
    output logic [K-1:0] bits,
    output logic         ser_out
);

    logic [K-1:0] link;

    for (genvar i = 0; i < K; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign link[i] = ser_in;
        end else begin : g_body
            assign link[i] = bits[i-1];
        end

        scanreg_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .func_d     (load_val[i]),
            .func_load  (cap_go),
            .chain_d    (link[i]),
            .chain_load (shf_go),
            .q          (bits[i])
        );
    end

    assign ser_out = bits[K-1];

    // R2: a shift moves every bit one place along the chain.
    a_r2_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shf_go && !cap_go |=> bits == {$past(bits[K-2:0]), $past(ser_in)});

endmodule

// File: rtl/scanreg_ctrl.sv
module scanreg_ctrl
    import scanreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck_req,
    input  logic tck_req,
    output logic cap_go,
    output logic shf_go,
    output logic clash
);

    scan_op_e op_q, op_d;

    always_comb begin
        op_d = op_q;
        unique case (op_q)
            OP_REST, OP_CAPTURE, OP_SHIFT: begin
                if (sck_req && tck_req)
                    op_d = OP_CLASH;
                else if (sck_req)
                    op_d = OP_CAPTURE;
                else if (tck_req)
                    op_d = OP_SHIFT;
                else
                    op_d = OP_REST;
            end
            OP_CLASH: op_d = OP_CLASH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            op_q <= OP_REST;
        else
            op_q <= op_d;
    end

    always_comb begin
        cap_go = sck_req && !tck_req;
        shf_go = tck_req && !sck_req;
        clash  = (op_q == OP_CLASH);
    end

    // R7: the error flag rises only after a cycle with both strobes.
    a_r7_clash_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clash) |-> $past(sck_req && tck_req));
    // R7: the error flag is sticky until reset.
    a_r7_clash_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> clash);
    // R7: at most one data port loads in any cycle.
    a_r7_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_go && shf_go));

endmodule

// File: rtl/scanpath_reg.sv
module scanpath_reg #(
    parameter int K = 6,
    parameter int N = 3,
    parameter int M = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sck_en,
    input  logic         tck_en,
    input  logic         sdi,
    input  logic [N-1:0] x_in,
    output logic [M-1:0] z_out,
    output logic         sdo,
    output logic         clash_err
);

    logic         cap_go, shf_go;
    logic [K-1:0] state_q, state_nx;

    scanreg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_req (sck_en),
        .tck_req (tck_en),
        .cap_go  (cap_go),
        .shf_go  (shf_go),
        .clash   (clash_err)
    );

    scanreg_logic #(.K(K), .N(N), .M(M)) u_logic (
        .cur_state  (state_q),
        .pin_in     (x_in),
        .next_state (state_nx),
        .pin_out    (z_out)
    );

    scanreg_chain #(.K(K)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (state_nx),
        .cap_go   (cap_go),
        .shf_go   (shf_go),
        .ser_in   (sdi),
        .bits     (state_q),
        .ser_out  (sdo)
    );

    // R3: a functional strobe stores the next-state vector.
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        sck_en && !tck_en |=> state_q == $past(state_nx));
    // R6: no strobe, no change.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_en && !tck_en |=> $stable(state_q));
    // R7: a clash cycle holds the state and raises the flag.
    a_r7_clash_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sck_en && tck_en |=> $stable(state_q) && clash_err);
    // R2: serial output follows the last state bit.
    a_r2_sdo_tail: assert property (@(posedge clk) disable iff (!rst_n)
        sdo == state_q[K-1]);

endmodule

// File: tb/scanpath_reg_tb_top.sv
module scanpath_reg_tb_top;

    localparam int K = 6;
    localparam int N = 3;
    localparam int M = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck_en = 1'b0, tck_en = 1'b0, sdi = 1'b0;
    logic [N-1:0] x_in = '0;
    logic [M-1:0] z_out;
    logic         sdo, clash_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    scanpath_reg #(.K(K), .N(N), .M(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck_en(sck_en), .tck_en(tck_en),
        .sdi(sdi), .x_in(x_in), .z_out(z_out), .sdo(sdo), .clash_err(clash_err)
    );

    function automatic logic [K-1:0] f_next(logic [K-1:0] s, logic [N-1:0] x);
        logic [K-1:0] r;
        for (int i = 0; i < K; i++) r[i] = s[(i + K - 1) % K] ^ x[i % N];
        return r;
    endfunction

    function automatic logic [M-1:0] f_out(logic [K-1:0] s, logic [N-1:0] x);
        logic [M-1:0] r;
        for (int j = 0; j < M; j++) r[j] = s[j % K] ^ s[(j + 1) % K] ^ x[j % N];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle, then sample 2 ns after the rising edge.
    task automatic cyc(logic s, logic t, logic d, logic [N-1:0] x);
        sck_en = s; tck_en = t; sdi = d; x_in = x;
        @(posedge clk); #2;
        sck_en = 1'b0; tck_en = 1'b0;
    endtask

    logic [K-1:0] model;

    // R8: K shifts unload model while loading nv; x is random to show it is ignored (R2).
    task automatic load_unload(logic [K-1:0] nv);
        for (int j = 0; j < K; j++) begin
            check("R8_unload", sdo, model[K-1-j]);
            cyc(1'b0, 1'b1, nv[K-1-j], N'($urandom));
        end
        model = nv;
    endtask

    initial begin
        logic [N-1:0] xv;
        logic [K-1:0] v;
        void'($urandom(32'h5C4A_11E7));
        repeat (2) @(posedge clk);
        #2;
        // R1: reset state
        check("R1_sdo", sdo, 0);
        check("R1_err", clash_err, 0);
        check("R5_reset_z", z_out, f_out('0, x_in));
        rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1_err_after", clash_err, 0);
        model = '0;

        // Directed: all-ones, alternating, single bit at each end.
        load_unload('1);
        load_unload(6'b101010);
        load_unload(6'b100000);
        check("R8_first_in_last", sdo, 1);
        load_unload(6'b000001);

        // R6: idle cycles with random sdi and x leave the state alone.
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'($urandom), N'($urandom));
        check("R6_hold_sdo", sdo, model[K-1]);

        // Random vectors: load, settle, check outputs, capture, unload next time.
        for (int n = 0; n < 60; n++) begin
            v  = K'($urandom);
            xv = N'($urandom);
            load_unload(v);
            x_in = xv; #1;
            check("R5_z", z_out, f_out(model, xv));
            cyc(1'b1, 1'b0, 1'($urandom), xv);
            model = f_next(model, xv);  // R3, R4
            if (n % 7 == 0)
                for (int i = 0; i < 2; i++) cyc(1'b0, 1'b0, 1'($urandom), N'($urandom));
        end
        load_unload(6'b110011);
        check("R7_no_err_yet", clash_err, 0);

        // R7: both strobes together hold the state and set the sticky flag.
        cyc(1'b1, 1'b1, ~model[0], 3'b111);
        check("R7_err_set", clash_err, 1);
        check("R7_hold_sdo", sdo, model[K-1]);
        cyc(1'b0, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, 3'b010);
        model = f_next(model, 3'b010);
        check("R7_sticky", clash_err, 1);
        load_unload(6'b011110);

        // R1: reset clears the flag and the state.
        rst_n = 1'b0;
        @(posedge clk); #2;
        rst_n = 1'b1;
        check("R1_err_cleared", clash_err, 0);
        model = '0;
        load_unload('0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule